// File: doc/BRIEF.md
# Four-Channel Synchronized DAC Update Controller

This block keeps four 12-bit setpoints for an external four-channel serial DAC and moves them to the converter together. Software writes any channel register with the trigger bit clear to stage a new code. The analog outputs do not change on such a write. A later write to any channel with the trigger bit set starts one update. The update shifts all four channels out in a fixed order and then pulses a load strobe, so every output changes at the same moment.

The register interface is 16 bits wide, with a separate write port and read port. Each channel register holds its code in bits 11:0, and bit 15 is the trigger/busy bit. On a read, bit 15 shows whether an update is still running. Writes that arrive during an update are dropped, so the codes being sent cannot change mid-transfer. Toward the DAC the block drives a serial clock, an active-low chip select, a data line and a load strobe. All four of these come straight from flip-flops.

Top module: `dac_sync_ctrl`

## Requirements
- R1: After reset every channel code reads 0, bit 15 reads 0, `dac_csn` is high, and `dac_sclk` and `dac_load` are low.
- R2: A write with bit 15 clear to a channel register (byte address BASE_ADDR + 2*channel, channels 0 to 3, default base 0x40) stores wr_data[11:0] as that channel's code and starts no serial activity. A read of that address returns the code in bits 11:0, and bits 14:12 always read 0.
- R3: A write with bit 15 set to any channel register stores that code and starts an update. A read issued in the cycle after the write returns bit 15 = 1.
- R4: An update sends four 16-bit frames, channel 0 first and channel 3 last, MSB first. Each frame is {channel[1:0], 2'b01, code[11:0]} and is framed by one low period of `dac_csn`. `dac_sdo` is valid at each rising edge of `dac_sclk`.
- R5: Every update carries all four channels, including channels whose code was not written since the previous update.
- R6: After the last frame, with `dac_csn` high, `dac_load` pulses high for exactly one clock. Each update produces exactly one such pulse.
- R7: Bit 15 reads 1 for the whole update and returns to 0 after the load pulse. At the default parameters, trigger to cleared busy takes at most 300 clocks (3 us at 100 MHz).
- R8: While an update runs, writes to channel registers are ignored. They change no code and start no second update.
- R9: Writes to addresses that are not channel registers (outside the four-word window, or odd byte addresses) have no effect. Reads of them return 0.
- R10: `dac_sclk` stays low whenever `dac_csn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 16 | Write data: bit 15 trigger, bits 11:0 code |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 16 | Read data, registered one clock after rd_addr |
| dac_sclk | output | 1 | Serial clock to the DAC, idle low |
| dac_csn | output | 1 | Active-low chip select, one low period per frame |
| dac_sdo | output | 1 | Serial data to the DAC, MSB first |
| dac_load | output | 1 | One-clock strobe that commits all DAC outputs |

## Verification
A stuck or mis-ordered sequencer shows up in the first update after it goes wrong. The frame order, the channel field or the code field of a captured frame will be wrong, or the load pulse will be missing or doubled. A busy flag that clears too early or never clears shows on the next polled read, either as a short busy window or as a window past the 300-clock bound. A shadow register that takes a write during busy shows on the next readback and again in the next update's frames. Random staging patterns between triggers show whether an unchanged channel is still resent from its held value.

// File: rtl/dac_sync_pkg.sv
package dac_sync_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GAP   = 2'd2,
    SEQ_LOAD  = 2'd3
  } seq_state_e;

  // command bits placed between the channel field and the code
  localparam logic [1:0] FRAME_CMD_UPDATE = 2'b01;
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
  parameter int CH_N = 4,
  parameter int CH_AW = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_AW-1:0]  sel
);
  localparam int WIN_LSB = CH_AW + 1;

  always_comb begin
    sel = addr[CH_AW:1];
    hit = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]) &&
          !addr[0] &&
          ({1'b0, sel} < (CH_AW+1)'(CH_N));
  end
endmodule

// File: rtl/dac_shadow_bank.sv
module dac_shadow_bank #(
  parameter int CH_N = 4,
  parameter int CODE_W = 12,
  parameter int CH_AW = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [CH_AW-1:0]         wsel,
  input  logic [CODE_W-1:0]        wcode,
  input  logic [CH_AW-1:0]         rsel,
  output logic [CODE_W-1:0]        rcode,
  output logic [CH_N*CODE_W-1:0]   codes_flat
);
  for (genvar g = 0; g < CH_N; g++) begin : g_chan
    logic [CODE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (we && (wsel == CH_AW'(g)))
        q <= wcode;
    end
    assign codes_flat[g*CODE_W +: CODE_W] = q;
  end

  assign rcode = codes_flat[rsel*CODE_W +: CODE_W];
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter
  import dac_sync_pkg::*;
#(
  parameter int CH_N = 4,
  parameter int CODE_W = 12,
  parameter int CH_AW = 2,
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [CH_N*CODE_W-1:0] codes_flat,
  output logic                   sclk,
  output logic                   csn,
  output logic                   sdo,
  output logic                   load,
  output logic                   done
);
  localparam int FRAME_W = CH_AW + 2 + CODE_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int DIV_W   = $clog2(2*HALF_DIV);
  localparam int GAP_W   = $clog2(GAP_CYC+1);

  seq_state_e             state;
  logic [CH_AW-1:0]       ch_idx;
  logic [CH_AW-1:0]       ch_nxt;
  logic [BIT_W-1:0]       bit_cnt;
  logic [DIV_W-1:0]       div_cnt;
  logic [GAP_W-1:0]       gap_cnt;
  logic [FRAME_W-1:0]     sreg;
  logic [FRAME_W-1:0]     first_frame;
  logic [FRAME_W-1:0]     next_frame;
  logic                   bit_end;
  logic                   last_ch;

  always_comb begin
    ch_nxt      = ch_idx + 1'b1;
    first_frame = {CH_AW'(0), FRAME_CMD_UPDATE, codes_flat[0 +: CODE_W]};
    next_frame  = {ch_nxt, FRAME_CMD_UPDATE, codes_flat[ch_nxt*CODE_W +: CODE_W]};
    bit_end     = (div_cnt == DIV_W'(2*HALF_DIV-1));
    last_ch     = (ch_idx == CH_AW'(CH_N-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      ch_idx  <= '0;
      bit_cnt <= '0;
      div_cnt <= '0;
      gap_cnt <= '0;
      sreg    <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state   <= SEQ_SHIFT;
            ch_idx  <= '0;
            bit_cnt <= '0;
            div_cnt <= '0;
            sreg    <= first_frame;
          end
        end
        SEQ_SHIFT: begin
          div_cnt <= div_cnt + 1'b1;
          if (bit_end) begin
            div_cnt <= '0;
            sreg    <= {sreg[FRAME_W-2:0], 1'b0};
            if (bit_cnt == BIT_W'(FRAME_W-1)) begin
              state   <= SEQ_GAP;
              gap_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        SEQ_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_W'(GAP_CYC-1)) begin
            if (last_ch) begin
              state <= SEQ_LOAD;
            end else begin
              state   <= SEQ_SHIFT;
              ch_idx  <= ch_nxt;
              bit_cnt <= '0;
              div_cnt <= '0;
              sreg    <= next_frame;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // registered pin drivers, one clock behind the sequencer state
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b0;
      csn  <= 1'b1;
      sdo  <= 1'b0;
      load <= 1'b0;
    end else begin
      sclk <= (state == SEQ_SHIFT) && (div_cnt >= DIV_W'(HALF_DIV));
      csn  <= (state != SEQ_SHIFT);
      sdo  <= (state == SEQ_SHIFT) && sreg[FRAME_W-1];
      load <= (state == SEQ_LOAD);
    end
  end

  assign done = load;
endmodule

// File: rtl/dac_sync_ctrl.sv
module dac_sync_ctrl #(
  parameter int CH_N = 4,
  parameter int CODE_W = 12,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              dac_sclk,
  output logic              dac_csn,
  output logic              dac_sdo,
  output logic              dac_load
);
  localparam int CH_AW    = $clog2(CH_N);
  localparam int TRIG_BIT = DATA_W - 1;
  localparam int PAD_W    = DATA_W - 1 - CODE_W;

  logic                   wr_hit, rd_hit;
  logic [CH_AW-1:0]       wr_sel, rd_sel;
  logic [CODE_W-1:0]      rd_code;
  logic [CH_N*CODE_W-1:0] codes_flat;
  logic                   accept, trig;
  logic                   busy_q, go_q, seq_done;
  logic                   unused_bits;

  assign unused_bits = ^wr_data[TRIG_BIT-1:CODE_W];

  dac_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CH_N(CH_N), .CH_AW(CH_AW))
    u_wdec (.addr(wr_addr), .hit(wr_hit), .sel(wr_sel));

  dac_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CH_N(CH_N), .CH_AW(CH_AW))
    u_rdec (.addr(rd_addr), .hit(rd_hit), .sel(rd_sel));

  assign accept = wr_en && wr_hit && !busy_q;
  assign trig   = accept && wr_data[TRIG_BIT];

  dac_shadow_bank #(.CH_N(CH_N), .CODE_W(CODE_W), .CH_AW(CH_AW)) u_bank (
    .clk(clk), .rst(rst), .we(accept), .wsel(wr_sel), .wcode(wr_data[CODE_W-1:0]),
    .rsel(rd_sel), .rcode(rd_code), .codes_flat(codes_flat)
  );

  dac_frame_shifter #(.CH_N(CH_N), .CODE_W(CODE_W), .CH_AW(CH_AW),
                      .HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(go_q), .codes_flat(codes_flat),
    .sclk(dac_sclk), .csn(dac_csn), .sdo(dac_sdo), .load(dac_load), .done(seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      rd_data <= '0;
    end else begin
      go_q <= trig;
      if (trig)
        busy_q <= 1'b1;
      else if (seq_done)
        busy_q <= 1'b0;
      rd_data <= rd_hit ? {busy_q, {PAD_W{1'b0}}, rd_code} : '0;
    end
  end
endmodule

// File: rtl/dac_sync_chk.sv
module dac_sync_chk #(
  parameter int CODES_W = 48
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               sclk,
  input logic               csn,
  input logic               load,
  input logic [CODES_W-1:0] codes
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (csn && !load && !busy)); // R1

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    csn |-> !sclk); // R10

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load |=> !load); // R6

  AST_LOAD_FRAMED: assert property (@(posedge clk) disable iff (rst)
    load |-> (csn && busy)); // R6

  AST_SHIFT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !csn |-> busy); // R7

  AST_BUSY_ENDS_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(load)); // R7

  AST_CODES_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(codes)); // R8
endmodule

bind dac_sync_ctrl dac_sync_chk #(.CODES_W(CH_N*CODE_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_q), .sclk(dac_sclk), .csn(dac_csn),
  .load(dac_load), .codes(codes_flat)
);

// File: tb/dac_sync_ctrl_bench.sv
module dac_sync_ctrl_bench;
  localparam logic [7:0] BASE = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        dac_sclk, dac_csn, dac_sdo, dac_load;

  int checks = 0;
  int fails = 0;
  logic [11:0] model [4];

  logic [15:0] frames [256];
  int          fbits [256];
  int          nfr = 0;
  int          nload = 0;
  int          nwide = 0;
  int          nsclk_bad = 0;
  logic [15:0] sh = '0;
  int          nbits = 0;
  logic        p_sclk = 1'b0;
  logic        p_csn = 1'b1;
  logic        p_load = 1'b0;

  always #5 clk = ~clk;

  dac_sync_ctrl u_dac_sync_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dac_sclk(dac_sclk), .dac_csn(dac_csn),
    .dac_sdo(dac_sdo), .dac_load(dac_load)
  );

  // serial monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (dac_sclk && !p_sclk && !dac_csn) begin
        sh = {sh[14:0], dac_sdo};
        nbits++;
      end
      if (dac_sclk && dac_csn) nsclk_bad++;
      if (dac_csn && !p_csn) begin
        if (nfr < 256) begin
          frames[nfr] = sh;
          fbits[nfr] = nbits;
        end
        nfr++;
        nbits = 0;
      end
      if (dac_load) nload++;
      if (dac_load && p_load) nwide++;
    end
    p_sclk = dac_sclk;
    p_csn  = dac_csn;
    p_load = dac_load;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [15:0] exp_frame(input int ch);
    return {ch[1:0], 2'b01, model[ch]};
  endfunction

  task automatic do_update(input int ch, input logic [11:0] code, input bit poke_busy);
    int base, l0, cyc;
    logic [15:0] d;
    base = nfr; l0 = nload;
    wr(BASE + 8'(2*ch), {4'h8, code});
    model[ch] = code;
    rd(BASE, d);
    chk(d[15] == 1'b1, "R3 busy after trigger", int'(d[15]), 1);
    if (poke_busy) begin
      wr(BASE + 8'd2, 16'h0555);       // R8: dropped
      wr(BASE + 8'd6, 16'h8AAA);       // R8: dropped, no second update
      rd(BASE + 8'd2, d);
      chk(d[15] == 1'b1, "R7 busy mid-update", int'(d[15]), 1);
    end
    cyc = 1;
    while (d[15] && cyc < 1000) begin
      rd(BASE, d);
      cyc++;
    end
    chk(cyc <= 300, "R7 update length", cyc, 300);
    repeat (400) @(negedge clk);
    chk(nfr - base == 4, "R4 frame count", nfr - base, 4);
    for (int i = 0; i < 4; i++) begin
      if (base + i < 256) begin
        chk(frames[base+i] == exp_frame(i), "R4 R5 frame content",
            int'(frames[base+i]), int'(exp_frame(i)));
        chk(fbits[base+i] == 16, "R4 frame length", fbits[base+i], 16);
      end
    end
    chk(nload - l0 == 1, "R6 load pulses", nload - l0, 1);
    for (int i = 0; i < 4; i++) begin
      rd(BASE + 8'(2*i), d);
      chk(d == {4'h0, model[i]}, "R8 readback after update", int'(d), int'({4'h0, model[i]}));
    end
  endtask

  initial begin
    logic [15:0] d;
    int unsigned seed;
    int n0;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    chk(dac_csn && !dac_sclk && !dac_load, "R1 pins in reset",
        int'({dac_csn, dac_sclk, dac_load}), 3'b100);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd(BASE + 8'(2*i), d);
      chk(d == 16'h0000, "R1 reset readback", int'(d), 0);
    end

    // R2: staging only
    n0 = nfr;
    wr(BASE + 8'd4, 16'h7ABC);
    model[2] = 12'hABC;
    repeat (20) @(negedge clk);
    rd(BASE + 8'd4, d);
    chk(d == 16'h0ABC, "R2 staged readback", int'(d), 16'h0ABC);
    chk(nfr == n0 && nload == 0, "R2 no serial activity", nfr - n0, 0);

    // R3..R7: trigger from channel 0, channels 1 and 3 unchanged
    do_update(0, 12'h123, 1'b0);
    // R8: writes during busy dropped
    do_update(3, 12'hFFF, 1'b1);

    // R9: unmapped writes and reads
    n0 = nfr;
    wr(BASE + 8'd8, 16'h8111);
    wr(BASE + 8'd1, 16'h8222);
    wr(8'h00, 16'h8333);
    repeat (30) @(negedge clk);
    chk(nfr == n0, "R9 no update from unmapped write", nfr - n0, 0);
    rd(BASE, d);
    chk(d == {4'h0, model[0]}, "R9 channel 0 untouched", int'(d), int'({4'h0, model[0]}));
    rd(BASE + 8'd8, d);
    chk(d == 16'h0000, "R9 unmapped read", int'(d), 0);
    rd(BASE + 8'd3, d);
    chk(d == 16'h0000, "R9 odd address read", int'(d), 0);

    // random staging followed by a trigger from a random channel
    for (int it = 0; it < 20; it++) begin
      int nw;
      nw = int'($urandom_range(0, 4));
      for (int k = 0; k < nw; k++) begin
        int c;
        logic [11:0] v;
        c = int'($urandom_range(0, 3));
        v = 12'($urandom);
        wr(BASE + 8'(2*c), {1'b0, 3'($urandom), v});
        model[c] = v;
      end
      do_update(int'($urandom_range(0, 3)), 12'($urandom), (it % 5) == 0);
    end
    // directed extremes
    do_update(1, 12'h000, 1'b0);
    do_update(2, 12'hFFF, 1'b0);

    chk(nsclk_bad == 0, "R10 sclk while deselected", nsclk_bad, 0);
    chk(nwide == 0, "R6 load width", nwide, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule